// File: doc/BRIEF.md
# Framed Speech Codec Host Link

This block sits on the host side of a speech codec coprocessor and moves compressed speech, one frame at a time, between a local byte stream and the coprocessor's narrow parallel bus. The coprocessor works on 16-bit words. The link reaches it over an 8-bit bus, sending each word as two bytes and marking which half is on the bus with a half-select line. Reads and writes each have their own strobe.

A session starts when `run` is raised. In record mode the link sends a compress command and in playback mode a decompress command. The command word carries the chosen coded rate. After that, every frame follows the same pattern:

1. Wait until the coprocessor raises `ack`.
2. Read a 16-bit status word.
3. Take the frame's byte count from the low byte of that word.
4. Move exactly that many bytes, before a hard deadline.

In record mode, bytes come out of the coprocessor and go into the output stream. In playback mode, bytes are taken from the input stream and written to the coprocessor.

The link checks each count against a maximum of 36 bytes, which is one 30 ms frame at the highest rate. It also runs a deadline counter for every frame. If a count is too large, or the deadline expires, the link sets a sticky flag and halts. It stays halted until `run` is dropped. The flags clear when the next session starts.

Top module: `speech_frame_link`

## Requirements
- R1: While reset is held, `rdStb`, `wrStb`, `inReady`, `outValid`, `frameDone`, `overrun` and `countErr` are all 0.
- R2: A session starts from idle when `run` is high. In the cycle after `run` is first seen high, the link writes the command high byte with `hiSel`=1:
  - 0xC1 when `recMode`=1 (record);
  - 0xC2 when `recMode`=0 (playback).
  
  In the next cycle it writes the low byte with `hiSel`=0. The low byte is `{6'b0, rateSel}`, where 0 selects 9.6 kbps, 1 selects 7.2 kbps and 2 selects 4.4 kbps.
- R3: The link waits for `ack`. It then issues two consecutive read strobes: the first with `hiSel`=1, the second with `hiSel`=0. The low byte read with the second strobe is the frame's byte count.
- R4: In record mode the link issues exactly `count` read strobes. Each one falls in a cycle where `ack` is high and the output holding slot is free. The bytes appear on `outData`/`outValid` in the order they were read, and they stay stable while `outReady` is low.
- R5: In playback mode the link issues exactly `count` write strobes. Each one falls in a cycle where `inValid` is high, with `busOut`=`inData`. `inReady` is high only in those cycles.
- R6: Within a frame, the first data byte goes with `hiSel`=1, and the value then alternates on each byte.
- R7: `frameDone` pulses in the cycle of the frame's last byte strobe. When the count is 0, it pulses instead in the cycle of the status low read. The link then waits for the next status word without sending another command.
- R8: If the count is greater than 36, the link sets `countErr`, moves no data and halts.
- R9: The deadline is FRAME_CYCLES cycles. It runs from the cycle after the status low read. A byte moved in the FRAME_CYCLES-th cycle is on time. If the count has not been reached by then, `overrun` goes to 1 one cycle later and the link halts.
- R10: While the link is halted, `overrun` and `countErr` hold their value and no strobe is issued. Both flags return to 0 in the first command cycle of the next session.
- R11: If `run` is low while the link is waiting for a status word, the link returns to idle and issues no strobes.
- R12: `rdStb` and `wrStb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | Session enable |
| recMode | input | 1 | 1 = record, 0 = playback; latched when a session starts |
| rateSel | input | 2 | Coded rate code carried in the command low byte |
| ack | input | 1 | Coprocessor has data ready for the host |
| busIn | input | 8 | Byte driven by the coprocessor |
| busOut | output | 8 | Byte driven towards the coprocessor |
| hiSel | output | 1 | 1 = high half of the 16-bit word is on the bus |
| rdStb | output | 1 | Host read strobe |
| wrStb | output | 1 | Host write strobe |
| inData | input | 8 | Playback stream byte |
| inValid | input | 1 | Playback stream byte valid |
| inReady | output | 1 | Playback byte taken this cycle |
| outData | output | 8 | Record stream byte |
| outValid | output | 1 | Record stream byte valid |
| outReady | input | 1 | Record stream sink ready |
| frameDone | output | 1 | Pulse when a frame's transfer completes |
| overrun | output | 1 | Sticky deadline-miss flag |
| countErr | output | 1 | Sticky oversize-count flag |

## Verification
- **Strobe timing.** All strobes, `hiSel`, `busOut` and `inReady` are decoded from the current state and the inputs of the same cycle. The command therefore shows up in the first sample after `run` is taken, and the status reads follow one cycle after `ack` is seen.
- **How sampling works.** The bench drives its stub coprocessor and stream inputs just after the falling edge. It samples one nanosecond later, so each sample shows exactly what the next rising edge acts on. The reference model advances one step per sample.
- **Flag and stream timing.** Registered results appear one sample after the edge that makes them: a record byte on `outData`, and either flag. The deadline checks count samples from the status low read:
  - a byte at sample +FRAME_CYCLES must be accepted without error;
  - `overrun` must still be 0 at +FRAME_CYCLES+1 and must be 1 at +FRAME_CYCLES+2.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMDH,
    S_CMDL,
    S_STWAIT,
    S_STH,
    S_STL,
    S_DATA,
    S_HALT
  } state_e;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic loadCount;
    logic decCount;
    logic loadDeadline;
    logic tickDeadline;
    logic clrPhase;
    logic togglePhase;
    logic captureByte;
    logic setOverrun;
    logic setCountErr;
    logic clrFlags;
  } ctl_s;

endpackage

// File: rtl/sfl_dpath.sv
module sfl_dpath
  import sfl_pkg::*;
#(
  parameter int MAX_BYTES    = 36,
  parameter int FRAME_CYCLES = 6000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctl_s       ctl,
  input  logic [7:0] busIn,
  input  logic       outReady,
  output logic       countIsOne,
  output logic       countTooBig,
  output logic       countZeroIn,
  output logic       deadlineZero,
  output logic       hiPhase,
  output logic       holdFree,
  output logic [7:0] outData,
  output logic       outValid,
  output logic       overrun,
  output logic       countErr
);

  localparam int CNT_W = $clog2(MAX_BYTES + 1);
  localparam int DL_W  = $clog2(FRAME_CYCLES + 1);

  logic [CNT_W-1:0] count;
  logic [DL_W-1:0]  deadline;

  // Status low byte checks, evaluated while the byte is on the bus.
  assign countTooBig  = int'(busIn) > MAX_BYTES;
  assign countZeroIn  = busIn == 8'd0;
  assign countIsOne   = count == CNT_W'(1);
  assign deadlineZero = deadline == '0;
  assign holdFree     = !outValid || outReady;

  // Remaining bytes of the current frame.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (ctl.loadCount) begin
      count <= CNT_W'(busIn);
    end else if (ctl.decCount) begin
      count <= count - CNT_W'(1);
    end
  end

  // Per-frame deadline, counted down during the data phase.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      deadline <= '0;
    end else if (ctl.loadDeadline) begin
      deadline <= DL_W'(FRAME_CYCLES);
    end else if (ctl.tickDeadline && !deadlineZero) begin
      deadline <= deadline - DL_W'(1);
    end
  end

  // Byte-half tracker for data bytes.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiPhase <= 1'b1;
    end else if (ctl.clrPhase) begin
      hiPhase <= 1'b1;
    end else if (ctl.togglePhase) begin
      hiPhase <= !hiPhase;
    end
  end

  // One-byte holding slot towards the record stream.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData  <= 8'd0;
      outValid <= 1'b0;
    end else if (ctl.captureByte) begin
      outData  <= busIn;
      outValid <= 1'b1;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  // Sticky error flags.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      overrun  <= 1'b0;
      countErr <= 1'b0;
    end else if (ctl.clrFlags) begin
      overrun  <= 1'b0;
      countErr <= 1'b0;
    end else begin
      if (ctl.setOverrun)  overrun  <= 1'b1;
      if (ctl.setCountErr) countErr <= 1'b1;
    end
  end

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  p_no_late_byte_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.decCount |-> !deadlineZero);

endmodule

// File: rtl/sfl_ctrl.sv
module sfl_ctrl
  import sfl_pkg::*;
#(
  parameter logic [7:0] CMD_REC  = 8'hC1,
  parameter logic [7:0] CMD_PLAY = 8'hC2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       recMode,
  input  logic [1:0] rateSel,
  input  logic       ack,
  input  logic [7:0] inData,
  input  logic       inValid,
  input  logic       countIsOne,
  input  logic       countTooBig,
  input  logic       countZeroIn,
  input  logic       deadlineZero,
  input  logic       hiPhase,
  input  logic       holdFree,
  output ctl_s       ctl,
  output logic [7:0] busOut,
  output logic       hiSel,
  output logic       rdStb,
  output logic       wrStb,
  output logic       inReady,
  output logic       frameDone
);

  state_e state, nextState;
  logic   modeRec, modeNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      modeRec <= 1'b0;
    end else begin
      state   <= nextState;
      modeRec <= modeNext;
    end
  end

  always_comb begin
    nextState = state;
    modeNext  = modeRec;
    ctl       = '0;
    busOut    = 8'd0;
    hiSel     = 1'b0;
    rdStb     = 1'b0;
    wrStb     = 1'b0;
    inReady   = 1'b0;
    frameDone = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (run) begin
          modeNext     = recMode;
          ctl.clrFlags = 1'b1;
          nextState    = S_CMDH;
        end
      end
      S_CMDH: begin
        wrStb     = 1'b1;
        hiSel     = 1'b1;
        busOut    = modeRec ? CMD_REC : CMD_PLAY;
        nextState = S_CMDL;
      end
      S_CMDL: begin
        wrStb     = 1'b1;
        busOut    = {6'b0, rateSel};
        nextState = S_STWAIT;
      end
      S_STWAIT: begin
        if (!run)     nextState = S_IDLE;
        else if (ack) nextState = S_STH;
      end
      S_STH: begin
        rdStb     = 1'b1;
        hiSel     = 1'b1;
        nextState = S_STL;
      end
      S_STL: begin
        rdStb = 1'b1;
        if (countTooBig) begin
          ctl.setCountErr = 1'b1;
          nextState       = S_HALT;
        end else if (countZeroIn) begin
          frameDone = 1'b1;
          nextState = S_STWAIT;
        end else begin
          ctl.loadCount    = 1'b1;
          ctl.loadDeadline = 1'b1;
          ctl.clrPhase     = 1'b1;
          nextState        = S_DATA;
        end
      end
      S_DATA: begin
        hiSel = hiPhase;
        if (deadlineZero) begin
          ctl.setOverrun = 1'b1;
          nextState      = S_HALT;
        end else begin
          ctl.tickDeadline = 1'b1;
          if (modeRec) begin
            if (ack && holdFree) begin
              rdStb           = 1'b1;
              ctl.captureByte = 1'b1;
              ctl.decCount    = 1'b1;
              ctl.togglePhase = 1'b1;
            end
          end else if (inValid) begin
            wrStb           = 1'b1;
            inReady         = 1'b1;
            busOut          = inData;
            ctl.decCount    = 1'b1;
            ctl.togglePhase = 1'b1;
          end
          if (ctl.decCount && countIsOne) begin
            frameDone = 1'b1;
            nextState = S_STWAIT;
          end
        end
      end
      S_HALT: begin
        if (!run) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  p_no_dual_strobe_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStb && wrStb));

  p_ready_only_on_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (wrStb && inValid));

endmodule

// File: rtl/speech_frame_link.sv
module speech_frame_link
  import sfl_pkg::*;
#(
  parameter int          MAX_BYTES    = 36,
  parameter int          FRAME_CYCLES = 6000000,
  parameter logic [7:0]  CMD_REC      = 8'hC1,
  parameter logic [7:0]  CMD_PLAY     = 8'hC2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       recMode,
  input  logic [1:0] rateSel,
  input  logic       ack,
  input  logic [7:0] busIn,
  output logic [7:0] busOut,
  output logic       hiSel,
  output logic       rdStb,
  output logic       wrStb,
  input  logic [7:0] inData,
  input  logic       inValid,
  output logic       inReady,
  output logic [7:0] outData,
  output logic       outValid,
  input  logic       outReady,
  output logic       frameDone,
  output logic       overrun,
  output logic       countErr
);

  ctl_s ctl;
  logic countIsOne, countTooBig, countZeroIn, deadlineZero, hiPhase, holdFree;

  sfl_ctrl #(
    .CMD_REC (CMD_REC),
    .CMD_PLAY(CMD_PLAY)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .run         (run),
    .recMode     (recMode),
    .rateSel     (rateSel),
    .ack         (ack),
    .inData      (inData),
    .inValid     (inValid),
    .countIsOne  (countIsOne),
    .countTooBig (countTooBig),
    .countZeroIn (countZeroIn),
    .deadlineZero(deadlineZero),
    .hiPhase     (hiPhase),
    .holdFree    (holdFree),
    .ctl         (ctl),
    .busOut      (busOut),
    .hiSel       (hiSel),
    .rdStb       (rdStb),
    .wrStb       (wrStb),
    .inReady     (inReady),
    .frameDone   (frameDone)
  );

  sfl_dpath #(
    .MAX_BYTES   (MAX_BYTES),
    .FRAME_CYCLES(FRAME_CYCLES)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .busIn       (busIn),
    .outReady    (outReady),
    .countIsOne  (countIsOne),
    .countTooBig (countTooBig),
    .countZeroIn (countZeroIn),
    .deadlineZero(deadlineZero),
    .hiPhase     (hiPhase),
    .holdFree    (holdFree),
    .outData     (outData),
    .outValid    (outValid),
    .overrun     (overrun),
    .countErr    (countErr)
  );

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    countErr |-> !(rdStb || wrStb));

  p_ovr_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> !(rdStb || wrStb));

  p_done_on_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (rdStb || wrStb));

endmodule

// File: tb/speech_frame_link_tb.sv
`timescale 1ns/1ps
module speech_frame_link_tb;

  localparam int F   = 120;
  localparam int MAXB = 36;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic run = 1'b0, recMode = 1'b0, ack = 1'b0, inValid = 1'b0, outReady = 1'b0;
  logic [1:0] rateSel = 2'd0;
  logic [7:0] busIn = 8'd0, inData = 8'd0;
  logic [7:0] busOut, outData;
  logic hiSel, rdStb, wrStb, inReady, outValid, frameDone, overrun, countErr;

  always #2.5 clk = !clk;

  speech_frame_link #(.MAX_BYTES(MAXB), .FRAME_CYCLES(F)) u_dut (
    .clk(clk), .rstN(rstN), .run(run), .recMode(recMode), .rateSel(rateSel),
    .ack(ack), .busIn(busIn), .busOut(busOut), .hiSel(hiSel), .rdStb(rdStb),
    .wrStb(wrStb), .inData(inData), .inValid(inValid), .inReady(inReady),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .frameDone(frameDone), .overrun(overrun), .countErr(countErr)
  );

  int nChk = 0, nFail = 0, cyc = 0;
  // Reference model of the coprocessor and the streams.
  int ph = 0, gap = 0, curCnt = 0, idx = 0, stLoCyc = 0, seed = 8'h30;
  bit isRec = 0, srcEn = 0, srcGap = 0;
  string deadTag = "R8";
  logic [7:0] expOp = 8'h00, expRate = 8'h00;
  int cntQ[$];
  logic [7:0] recSrc[$], expOut[$], playSrc[$], expBus[$];

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    ack = (ph == 3) || (ph == 5 && isRec && idx < curCnt && (cyc % 4) != 3);
    if (ph == 3)                                  busIn = 8'hA5;
    else if (ph == 4)                             busIn = 8'(curCnt);
    else if (ph == 5 && isRec && recSrc.size() > 0) busIn = recSrc[0];
    else                                          busIn = 8'h00;
    inValid  = srcEn && playSrc.size() > 0 && !(srcGap && (cyc % 5) == 2);
    inData   = inValid ? playSrc[0] : 8'h00;
    outReady = (cyc % 3) != 0;
    #1;
    chk(!(rdStb && wrStb), "R12", {rdStb, wrStb}, 0);
    if (outValid && outReady) begin
      chk(expOut.size() > 0 && outData == expOut[0], "R4", outData,
          expOut.size() > 0 ? expOut[0] : 'hx);
      if (expOut.size() > 0) void'(expOut.pop_front());
    end
    if (inValid && inReady) void'(playSrc.pop_front());
    case (ph)
      0: begin
        chk(!rdStb, "R2", rdStb, 0);
        if (wrStb) begin
          chk(hiSel == 1'b1 && busOut == expOp, "R2", {hiSel, busOut}, {1'b1, expOp});
          ph = 1;
        end
      end
      1: begin
        chk(wrStb && !hiSel && busOut == expRate, "R2", {wrStb, hiSel, busOut},
            {1'b1, 1'b0, expRate});
        ph = 2; gap = 3;
      end
      2: begin
        chk(!rdStb && !wrStb, "R7", {rdStb, wrStb}, 0);
        if (gap > 0) gap--;
        if (gap == 0 && cntQ.size() > 0) begin
          curCnt = cntQ.pop_front();
          if (isRec && curCnt <= MAXB)
            for (int k = 0; k < curCnt; k++) begin
              recSrc.push_back(8'(seed));
              expOut.push_back(8'(seed));
              seed += 7;
            end
          ph = 3;
        end
      end
      3: begin
        chk(!wrStb, "R3", wrStb, 0);
        if (rdStb) begin
          chk(hiSel == 1'b1, "R3", hiSel, 1);
          ph = 4;
        end
      end
      4: begin
        chk(rdStb && !hiSel, "R3", {rdStb, hiSel}, 2'b10);
        stLoCyc = cyc;
        if (curCnt > MAXB) begin
          ph = 6; deadTag = "R8";
        end else if (curCnt == 0) begin
          chk(frameDone == 1'b1, "R7", frameDone, 1);
          ph = 2; gap = 2;
        end else begin
          chk(frameDone == 1'b0, "R7", frameDone, 0);
          ph = 5; idx = 0;
        end
      end
      5: begin
        if (isRec) begin
          chk(!wrStb, "R4", wrStb, 0);
          if (rdStb) begin
            chk(ack == 1'b1, "R4", ack, 1);
            chk(hiSel == ((idx % 2) == 0), "R6", hiSel, (idx % 2) == 0);
            chk(frameDone == (idx == curCnt - 1), "R7", frameDone, idx == curCnt - 1);
            void'(recSrc.pop_front());
            idx++;
          end else chk(!frameDone, "R7", frameDone, 0);
        end else begin
          chk(!rdStb, "R5", rdStb, 0);
          if (wrStb) begin
            chk(inValid && inReady, "R5", {inValid, inReady}, 2'b11);
            chk(expBus.size() > 0 && busOut == expBus[0], "R5", busOut,
                expBus.size() > 0 ? expBus[0] : 'hx);
            if (expBus.size() > 0) void'(expBus.pop_front());
            chk(hiSel == ((idx % 2) == 0), "R6", hiSel, (idx % 2) == 0);
            chk(frameDone == (idx == curCnt - 1), "R7", frameDone, idx == curCnt - 1);
            idx++;
          end else begin
            chk(!frameDone, "R7", frameDone, 0);
            chk(!inReady, "R5", inReady, 0);
          end
        end
        if (idx == curCnt) begin ph = 2; gap = 2; end
      end
      default: chk(!rdStb && !wrStb, deadTag, {rdStb, wrStb}, 0);
    endcase
  endtask

  task automatic startSession(bit rec, logic [1:0] rate);
    isRec = rec; recMode = rec; rateSel = rate;
    expOp = rec ? 8'hC1 : 8'hC2; expRate = {6'b0, rate};
    ph = 0; run = 1'b1;
    step();
    chk(ph == 1, "R2", ph, 1);  // command high byte in the first sample
  endtask

  task automatic waitIdleModel(int limit);
    for (int i = 0; i < limit; i++) begin
      if (ph == 2 && cntQ.size() == 0 && expOut.size() == 0 && expBus.size() == 0)
        break;
      step();
    end
  endtask

  initial begin
    repeat (3) step();
    chk(!rdStb && !wrStb && !inReady && !outValid && !frameDone && !overrun && !countErr,
        "R1", {rdStb, wrStb, inReady, outValid, frameDone, overrun, countErr}, 0);
    @(negedge clk); rstN = 1'b1;
    step();

    // Record session: regular, zero-length and maximum-length frames.
    cntQ = '{5, 0, MAXB};
    startSession(1'b1, 2'd1);
    waitIdleModel(3000);
    chk(ph == 2 && cntQ.size() == 0 && expOut.size() == 0, "R4", expOut.size(), 0);
    chk(!countErr && !overrun, "R8", {countErr, overrun}, 0);

    // Drop run while waiting for status: back to idle, no strobes.
    run = 1'b0;
    repeat (4) step();
    chk(!rdStb && !wrStb, "R11", {rdStb, wrStb}, 0);

    // Playback session with stream gaps, odd-length frame.
    for (int k = 0; k < 7; k++) begin
      playSrc.push_back(8'(8'h90 + 3 * k));
      expBus.push_back(8'(8'h90 + 3 * k));
    end
    srcEn = 1; srcGap = 1;
    cntQ = '{4, 3};
    startSession(1'b0, 2'd2);  // R11: restart issues the command at once
    waitIdleModel(3000);
    chk(expBus.size() == 0 && playSrc.size() == 0, "R5", expBus.size(), 0);
    run = 1'b0;
    step(); step();

    // Oversize count.
    srcEn = 0; srcGap = 0;
    cntQ = '{MAXB + 1};
    startSession(1'b0, 2'd0);
    for (int i = 0; i < 50 && ph != 6; i++) step();
    step();
    chk(countErr == 1'b1, "R8", countErr, 1);
    repeat (6) step();
    chk(countErr == 1'b1 && overrun == 1'b0, "R10", {countErr, overrun}, 2'b10);
    run = 1'b0;
    step(); step();

    // New session clears flags; last byte exactly at the deadline.
    playSrc.push_back(8'h11); expBus.push_back(8'h11);
    playSrc.push_back(8'h22); expBus.push_back(8'h22);
    cntQ = '{2, 3};
    startSession(1'b0, 2'd1);
    chk(countErr == 1'b0 && overrun == 1'b0, "R10", {countErr, overrun}, 0);
    for (int i = 0; i < 50 && ph != 5; i++) step();
    while (cyc < stLoCyc + F - 2) step();
    srcEn = 1;
    step(); step();
    chk(ph == 2 && expBus.size() == 0, "R9", expBus.size(), 0);
    step();
    chk(overrun == 1'b0, "R9", overrun, 0);

    // Deadline miss: no playback data for the next frame.
    for (int i = 0; i < 50 && ph != 5; i++) step();
    while (cyc < stLoCyc + F + 1) step();
    chk(overrun == 1'b0, "R9", overrun, 0);
    step();
    chk(overrun == 1'b1, "R9", overrun, 1);
    ph = 6; deadTag = "R10";
    repeat (5) step();
    chk(overrun == 1'b1, "R10", overrun, 1);
    run = 1'b0;
    repeat (3) step();

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule